// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single input-capture channel for a general-purpose timer. It watches two asynchronous pins, its own and the neighbouring channel's, plus one internal trigger line that is already synchronous to the clock. It also receives the value of a free-running counter that lives outside the block.

Each pin goes through a two-flop synchronizer and then a digital filter. An edge detector follows the filter, and its output is narrowed by a polarity choice. A 2-bit source select picks the event that commands a capture. Events then pass through a power-of-two prescaler and an enable gate. When a capture happens, the block latches the counter value into a capture register and raises a sticky capture flag. If a capture lands while that flag is still set, a sticky overcapture flag is also raised.

The polarity-selected, filtered edge of the channel's own pin is exported at all times, so that a slave-mode controller can use it as a trigger. The reset is asynchronous and active low. The chip's reset tree is expected to release it synchronously.

Top module: `tim_icap_chan`

## Requirements
- R1: After reset, cap_o is zero, and flag_o, ovr_o and edge_o are all low.
- R2: A pin level reaches the filter input after two synchronizer stages. With cfg_filt_i equal to N (N from 1 to 15), the filtered level changes only after N consecutive filter samples that differ from it. Code 0 behaves like code 1. From a pin change driven just after a clock edge, the own-pin edge therefore appears on edge_o in the cycle after clock edge N+2. Pulses shorter than N samples produce no edge.
- R3: Polarity cfg_pol_i selects the edge. 2'b00 and 2'b10 select rising edges, 2'b01 selects falling edges, and 2'b11 selects both.
- R4: Source select cfg_sel_i chooses the capture event. 2'b01 is the own-pin edge, 2'b10 is the neighbour-pin edge (using the same filter and polarity settings), and 2'b11 is trig_i sampled at the clock edge. With 2'b00, no capture ever occurs.
- R5: Prescale code cfg_psc_i equal to P makes a capture happen on every 2^P-th selected event (1, 2, 4 or 8 for a 2-bit code).
- R6: While cfg_en_i is low, no capture occurs. The prescaler's event count restarts from zero while cfg_en_i is low, while cfg_sel_i is 2'b00, and in any cycle in which cfg_psc_i differs from its value in the previous cycle. As a result, the first capture after such a restart needs a full 2^P events.
- R7: A capture loads cap_o, at that clock edge, with the value cnt_i had in the same cycle, and sets flag_o. flag_o then stays high until a cycle with flag_wr0_i high and no capture clears it. A capture in the same cycle as the clear wins.
- R8: A capture while flag_o is high, in a cycle without flag_wr0_i, sets ovr_o, and cap_o still takes the new value. ovr_o stays high until ovr_wr0_i is pulsed.
- R9: edge_o always carries the polarity-selected, filtered edge of the own pin, independent of cfg_sel_i and cfg_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_own_i | input | 1 | Channel's own asynchronous pin |
| pin_nbr_i | input | 1 | Neighbouring channel's asynchronous pin |
| trig_i | input | 1 | Internal trigger, synchronous to clk |
| cnt_i | input | CNT_W | Free-running counter value |
| cfg_filt_i | input | FILT_W | Filter sample count (0 acts as 1) |
| cfg_pol_i | input | 2 | Edge polarity select |
| cfg_sel_i | input | 2 | Capture source select |
| cfg_psc_i | input | PSC_W | Prescale exponent |
| cfg_en_i | input | 1 | Capture enable |
| flag_wr0_i | input | 1 | Pulse: software writes zero to the capture flag |
| ovr_wr0_i | input | 1 | Pulse: software writes zero to the overcapture flag |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Capture flag |
| ovr_o | output | 1 | Overcapture flag |
| edge_o | output | 1 | Filtered, polarity-selected own-pin edge for a slave controller |

## Verification
The hardest state to reach from the ports is a prescaler count that is part-way to its limit at the moment the count is restarted, either by dropping the enable or by changing the prescale code. From outside, a restart looks exactly like a lost event unless the events that follow are counted precisely. The stimulus therefore uses single-cycle trigger pulses, which avoid any filter latency, so that an exact number of events can be fed in. It then restarts the count in the middle and checks that the flag stays low until a full 2^P further events have arrived. A behavioural model compares all outputs on every clock while random pin traffic runs through the filters at several filter codes.

// File: rtl/tim_icap_pkg.sv
package tim_icap_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_OWN = 2'b01,
    SRC_NBR = 2'b10,
    SRC_TRG = 2'b11
  } src_e;

  // Pick the edge(s) that count as events: 01 falling, 11 both, else rising.
  function automatic logic pol_pick(input logic rise, input logic fall,
                                    input logic [1:0] pol);
    logic res;
    case (pol)
      2'b01:   res = fall;
      2'b11:   res = rise | fall;
      default: res = rise;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tim_icap_front.sv
module tim_icap_front #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic [FILT_W-1:0] filt_code,
  output logic              rise_o,
  output logic              fall_o
);

  logic [1:0]        sync_q, sync_d;
  logic              lvl_q, lvl_d, lvl_dly_q;
  logic [FILT_W-1:0] run_q, run_d, reload;

  // Down-counter: reloads while the sample agrees with the level,
  // and flips the level when it expires on a differing sample.
  always_comb begin
    reload = (filt_code == '0) ? '0 : filt_code - FILT_W'(1);
    sync_d = {sync_q[0], pin_a};
    lvl_d  = lvl_q;
    run_d  = run_q;
    if (sync_q[1] == lvl_q) begin
      run_d = reload;
    end else if (run_q == '0) begin
      lvl_d = sync_q[1];
      run_d = reload;
    end else begin
      run_d = run_q - FILT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      lvl_q     <= 1'b0;
      lvl_dly_q <= 1'b0;
      run_q     <= '0;
    end else begin
      sync_q    <= sync_d;
      lvl_q     <= lvl_d;
      lvl_dly_q <= lvl_q;
      run_q     <= run_d;
    end
  end

  assign rise_o = lvl_q & ~lvl_dly_q;
  assign fall_o = ~lvl_q & lvl_dly_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] == lvl_q) |=> $stable(lvl_q)); // R2

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o})); // R3

endmodule

// File: rtl/tim_icap_psc.sv
module tim_icap_psc #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev,
  input  logic [PSC_W-1:0] psc_code,
  output logic             hit_o
);

  localparam int PCNT_W = (1 << PSC_W) - 1;

  logic [PCNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = PCNT_W'((32'd1 << psc_code) - 32'd1);
    hit_o = ev & ~clr & (cnt_q == lim);
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (hit_o) cnt_d = '0;
    else if (ev)    cnt_d = cnt_q + PCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt_q <= lim)); // R5

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/tim_icap_chan.sv
module tim_icap_chan
  import tim_icap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4,
  parameter int PSC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_own_i,
  input  logic              pin_nbr_i,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FILT_W-1:0] cfg_filt_i,
  input  logic [1:0]        cfg_pol_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [PSC_W-1:0]  cfg_psc_i,
  input  logic              cfg_en_i,
  input  logic              flag_wr0_i,
  input  logic              ovr_wr0_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic              flag_o,
  output logic              ovr_o,
  output logic              edge_o
);

  localparam int NPIN = 2;

  logic [NPIN-1:0] pins, rise, fall, pedge;

  assign pins = {pin_nbr_i, pin_own_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_front
    tim_icap_front #(.FILT_W(FILT_W)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_a     (pins[g]),
      .filt_code (cfg_filt_i),
      .rise_o    (rise[g]),
      .fall_o    (fall[g])
    );
    assign pedge[g] = pol_pick(rise[g], fall[g], cfg_pol_i);
  end

  assign edge_o = pedge[0];

  // Source select and prescaler restart
  src_e             sel;
  logic             ev, psc_clr, fire;
  logic [PSC_W-1:0] psc_prev_q;

  always_comb begin
    sel = src_e'(cfg_sel_i);
    case (sel)
      SRC_OWN: ev = pedge[0];
      SRC_NBR: ev = pedge[1];
      SRC_TRG: ev = trig_i;
      default: ev = 1'b0;
    endcase
    psc_clr = ~cfg_en_i | (sel == SRC_OFF) | (cfg_psc_i != psc_prev_q);
  end

  tim_icap_psc #(.PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (psc_clr),
    .ev       (ev),
    .psc_code (cfg_psc_i),
    .hit_o    (fire)
  );

  // Capture register and flags
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d, ovr_q, ovr_d;

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    ovr_d  = ovr_q;
    if (flag_wr0_i) flag_d = 1'b0;
    if (ovr_wr0_i)  ovr_d  = 1'b0;
    if (fire) begin
      cap_d  = cnt_i;
      flag_d = 1'b1;
      if (flag_q && !flag_wr0_i) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q      <= '0;
      flag_q     <= 1'b0;
      ovr_q      <= 1'b0;
      psc_prev_q <= '0;
    end else begin
      psc_prev_q <= cfg_psc_i;
      flag_q     <= flag_d;
      ovr_q      <= ovr_d;
      if (fire) cap_q <= cap_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap_o == $past(cnt_i))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_wr0_i) |=> flag_o); // R7

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_i |=> $stable(cap_o)); // R6

  AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel_i == 2'b00) |=> $stable(cap_o)); // R4

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && fire && !flag_wr0_i) |=> ovr_o); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_wr0_i) |=> ovr_o); // R8

endmodule

// File: tb/tim_icap_chan_tb_top.sv
`timescale 1ns/1ps
module tim_icap_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_own, pin_nbr, trig;
  logic [15:0] cnt;
  logic [3:0]  filt;
  logic [1:0]  pol, sel, psc;
  logic        en, fclr, oclr;
  logic [15:0] cap;
  logic        flag, ovr, edg;

  always #2 clk = ~clk;

  tim_icap_chan dut_i (
    .clk(clk), .rst_n(rst_n), .pin_own_i(pin_own), .pin_nbr_i(pin_nbr),
    .trig_i(trig), .cnt_i(cnt), .cfg_filt_i(filt), .cfg_pol_i(pol),
    .cfg_sel_i(sel), .cfg_psc_i(psc), .cfg_en_i(en), .flag_wr0_i(fclr),
    .ovr_wr0_i(oclr), .cap_o(cap), .flag_o(flag), .ovr_o(ovr), .edge_o(edg)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;
  int    seen_edge = 0;
  int    lcg = 12345;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1[2], m_s2[2], m_lv[2], m_lvd[2], m_run[2];
  int m_pcnt, m_pprev, m_cap, m_flg, m_ovr;
  int e_exp;

  function automatic int pick(input int r, input int f, input int p);
    if (p == 1) return f;
    if (p == 3) return (r | f);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 0; m_s2[c] = 0; m_lv[c] = 0; m_lvd[c] = 0; m_run[c] = 0;
      end
      m_pcnt = 0; m_pprev = 0; m_cap = 0; m_flg = 0; m_ovr = 0; e_exp = 0;
    end else begin
      int e[2];
      int ev, hit, n;
      int pinv[2];
      pinv[0] = pin_own; pinv[1] = pin_nbr;
      for (int c = 0; c < 2; c++)
        e[c] = pick(m_lv[c] & ~m_lvd[c] & 1, ~m_lv[c] & m_lvd[c] & 1, pol);
      case (sel)
        1: ev = e[0];
        2: ev = e[1];
        3: ev = trig;
        default: ev = 0;
      endcase
      hit = 0;
      if (!en || sel == 0 || psc != m_pprev) m_pcnt = 0;
      else if (ev) begin
        if (m_pcnt == (1 << psc) - 1) begin hit = 1; m_pcnt = 0; end
        else m_pcnt++;
      end
      m_pprev = psc;
      if (hit) begin
        if (m_flg && !fclr) m_ovr = 1;
        else if (oclr) m_ovr = 0;
        m_cap = cnt; m_flg = 1;
      end else begin
        if (fclr) m_flg = 0;
        if (oclr) m_ovr = 0;
      end
      n = (filt == 0) ? 1 : filt;
      for (int c = 0; c < 2; c++) begin
        m_lvd[c] = m_lv[c];
        if (m_s2[c] != m_lv[c]) begin
          m_run[c]++;
          if (m_run[c] >= n) begin m_lv[c] = m_s2[c]; m_run[c] = 0; end
        end else m_run[c] = 0;
        m_s2[c] = m_s1[c];
        m_s1[c] = pinv[c];
      end
      e_exp = pick(m_lv[0] & ~m_lvd[0] & 1, ~m_lv[0] & m_lvd[0] & 1, pol);
    end
  end

  // One cycle: compare at the falling edge, then return pulses to idle.
  task automatic tick();
    @(negedge clk);
    checks++;
    if (edg !== e_exp[0] || cap !== m_cap[15:0] || flag !== m_flg[0] || ovr !== m_ovr[0]) begin
      fails++;
      $display("FAIL %s model: edge=%0d/%0d cap=%0d/%0d flag=%0d/%0d ovr=%0d/%0d",
               cur_req, edg, e_exp, cap, m_cap, flag, m_flg, ovr, m_ovr);
    end
    if (edg) seen_edge++;
    cnt  = cnt + 16'd1;
    trig = 1'b0; fclr = 1'b0; oclr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_trig(input int k);
    for (int i = 0; i < k; i++) begin trig = 1'b1; tick(); tick(); end
  endtask

  task automatic clear_flags();
    fclr = 1'b1; oclr = 1'b1; tick();
  endtask

  task automatic rand_pins(input int n);
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 1103515245 + 12345;
      if (((lcg >>> 16) & 7) == 0) pin_own = ~pin_own;
      if (((lcg >>> 20) & 7) == 0) pin_nbr = ~pin_nbr;
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; pin_own = 0; pin_nbr = 0; trig = 0; cnt = 16'd100;
    filt = 0; pol = 0; sel = 0; psc = 0; en = 0; fclr = 0; oclr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cap", cap, 0); check("R1 flag", flag, 0);
    check("R1 ovr", ovr, 0); check("R1 edge", edg, 0);
    rst_n = 1'b1;
    idle(4);

    // R2 latency, code 0
    cur_req = "R2";
    pin_own = 1; tick(); tick();
    check("R2 no edge yet", edg, 0);
    tick();
    check("R2 edge code0", edg, 1);
    pin_own = 0; idle(6);
    // R2 latency, code 4
    filt = 4; idle(3);
    pin_own = 1; idle(5);
    check("R2 no edge code4", edg, 0);
    tick();
    check("R2 edge code4", edg, 1);
    pin_own = 0; idle(10);
    // R2 glitch shorter than N rejected
    filt = 6; idle(3); seen_edge = 0;
    pin_own = 1; idle(4); pin_own = 0; idle(12);
    check("R2 glitch rejected", seen_edge, 0);
    pin_own = 1; idle(12);
    check("R2 long pulse passes", seen_edge, 1);
    pin_own = 0; idle(12);

    // R3 polarity
    cur_req = "R3"; filt = 0; pol = 2'b01; idle(3); seen_edge = 0;
    pin_own = 1; idle(6);
    check("R3 falling ignores rise", seen_edge, 0);
    pin_own = 0; idle(6);
    check("R3 falling sees fall", seen_edge, 1);
    pol = 2'b11; seen_edge = 0;
    pin_own = 1; idle(6); pin_own = 0; idle(6);
    check("R3 both edges", seen_edge, 2);
    pol = 2'b10; seen_edge = 0;
    pin_own = 1; idle(6); pin_own = 0; idle(6);
    check("R3 code 10 rising", seen_edge, 1);

    // R7 own-pin capture, flag sticky and clear
    cur_req = "R7"; pol = 0; sel = 2'b01; en = 1; idle(3);
    pin_own = 1; idle(10);
    check("R7 flag set", flag, 1);
    idle(20);
    check("R7 flag sticky", flag, 1);
    clear_flags();
    check("R7 flag cleared", flag, 0);
    pin_own = 0; idle(6);
    sel = 2'b11; idle(2);
    v = cnt; trig = 1; tick();
    check("R7 cap value", cap, v);
    check("R7 flag on trig", flag, 1);
    // R7 capture wins over same-cycle clear, no overcapture
    v = cnt; trig = 1; fclr = 1; tick();
    check("R7 capture wins clear", flag, 1);
    check("R8 no ovr on clear", ovr, 0);
    check("R7 cap value 2", cap, v);

    // R8 overcapture
    cur_req = "R8"; idle(2);
    v = cnt; trig = 1; tick();
    check("R8 ovr set", ovr, 1);
    check("R8 new value kept", cap, v);
    idle(5);
    check("R8 ovr sticky", ovr, 1);
    clear_flags();
    check("R8 ovr cleared", ovr, 0);

    // R4 source select
    cur_req = "R4"; sel = 2'b10; idle(2); v = cap;
    pin_own = 1; idle(8); pin_own = 0; idle(8);
    check("R4 own pin ignored on nbr sel", cap, v);
    check("R4 flag stays low", flag, 0);
    pin_nbr = 1; idle(8);
    check("R4 nbr captured", flag, 1);
    pin_nbr = 0; idle(4); clear_flags();
    sel = 2'b00; idle(2); v = cap;
    pulse_trig(4);
    pin_own = 1; pin_nbr = 1; idle(8); pin_own = 0; pin_nbr = 0; idle(8);
    check("R4 sel off no cap", cap, v);
    check("R4 sel off no flag", flag, 0);

    // R5 prescaler
    cur_req = "R5"; sel = 2'b11; psc = 3; idle(3); clear_flags();
    pulse_trig(7);
    check("R5 div8 before 8th", flag, 0);
    pulse_trig(1);
    check("R5 div8 at 8th", flag, 1);
    clear_flags(); psc = 1; idle(2);
    pulse_trig(1);
    check("R5 div2 after 1", flag, 0);
    pulse_trig(1);
    check("R5 div2 after 2", flag, 1);
    clear_flags();

    // R6 enable and restart
    cur_req = "R6"; psc = 2; idle(2);
    pulse_trig(3);
    en = 0; tick(); en = 1; idle(2);
    pulse_trig(3);
    check("R6 restart on disable", flag, 0);
    pulse_trig(1);
    check("R6 full count after enable", flag, 1);
    clear_flags();
    pulse_trig(3);
    psc = 1; idle(2);
    pulse_trig(1);
    check("R6 restart on psc change", flag, 0);
    pulse_trig(1);
    check("R6 count after psc change", flag, 1);
    clear_flags();
    en = 0; psc = 0; idle(2); v = cap;
    pulse_trig(3);
    check("R6 disabled no cap", cap, v);
    check("R6 disabled no flag", flag, 0);

    // R9 edge output independent of select and enable
    cur_req = "R9"; sel = 2'b11; seen_edge = 0;
    pin_own = 1; idle(6);
    check("R9 edge while disabled", seen_edge, 1);
    pin_own = 0; idle(6);

    // Random pin traffic under the model, several filter codes
    en = 1; sel = 2'b01; pol = 2'b11;
    for (int k = 0; k < 4; k++) begin
      cur_req = (k[0]) ? "R2 random" : "R5 random";
      filt = 4'(k * 3); psc = 2'(k); sel = (k == 2) ? 2'b10 : 2'b01;
      idle(20);
      rand_pins(1500);
      pin_own = 0; pin_nbr = 0; idle(40);
      clear_flags();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule